// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts 128-bit blocks under a 128-bit cipher key. Its ten cipher rounds are laid out in hardware one after another, not reused in a loop. A register sits after the initial key whitening and another after every round. A new plaintext block can be accepted on every clock. Each ciphertext leaves a fixed number of cycles after its plaintext entered, so the clock period is set by the delay of a single round.

The caller supplies all eleven round keys, already expanded, on one flat bus. That bus must not change while any block accepted under it is still inside the pipeline. A valid flag travels with each block and marks the cycles in which the output holds a real ciphertext. Key expansion and decryption are done elsewhere.

The stream interface has no ready signals. The input side can always accept a block, so a block is taken in every cycle in which `in_valid` is high. The output side cannot be stalled: the consumer must take `out_block` in every cycle in which `out_valid` is high, because that value is replaced on the next clock.

Top module: `aes128_pipe`

## Requirements
- R1: The block captured first is `in_block` XOR round key 0. With key bytes 00,01,…,0f and plaintext 00112233445566778899aabbccddeeff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: For every accepted block, `out_block` equals the AES-128 encryption of that block. Rounds 1 to 9 apply byte substitution, row rotation, column mixing and key addition. Round 10 leaves out the column mixing.
- R3: A block present with `in_valid` high before clock edge e appears on `out_block` with `out_valid` high after edge e+10. The output is valid in no earlier cycle.
- R4: Blocks presented on consecutive cycles leave on consecutive cycles, in order, one per clock.
- R5: Each cycle with `in_valid` low yields exactly one cycle with `out_valid` low, ten edges later. `out_valid` is never high without a matching accepted block.
- R6: While `rst` is high at a clock edge, every valid flag in the pipeline clears. `out_valid` then stays low until an accepted block has travelled the full depth.
- R7: Round key k (k = 0..10) is taken from `round_keys[1407-128k -: 128]`. Inside a block, byte i (i = 0..15) sits at bits `[127-8i -: 8]`, column-major: row i mod 4, column i div 4.
- R8: Each ciphertext is flagged valid for exactly one cycle.
- R9: A reset during streaming discards every block in flight, including any block presented in the reset cycle. None of them ever appears as valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Plaintext present on `in_block` this cycle |
| in_block | input | 128 | Plaintext block |
| round_keys | input | 1408 | Eleven expanded round keys, key 0 in the top 128 bits |
| out_valid | output | 1 | `out_block` holds a ciphertext this cycle |
| out_block | output | 128 | Ciphertext block |

## Verification
Two things routinely happen in the same cycle: a new block is whitened into the first stage while an older block finishes its last round and leaves, or while a bubble moves through the middle stages. The bench provokes this with long back-to-back streams and with streams full of irregular gaps. It judges every output cycle, valid flag and data alike, against a record of what entered eleven negative edges earlier. The expected ciphertexts come from an arithmetic model in the bench. A reset given while the pipeline is full, with a block presented in that same cycle, shows whether flushing and acceptance interfere.

// File: rtl/aes_pipe_pkg.sv
package aes_pipe_pkg;

  typedef logic [7:0] byte_t;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r;
    byte_t t;
    logic [7:0] e;
    r = 8'h01;
    t = a;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, t);
      t = gf_mul(t, t);
    end
    return r;
  endfunction

  function automatic byte_t subst(input byte_t x);
    byte_t v;
    v = gf_inv(x);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t dbl(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_pipe_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  assign dout = subst(din);
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_pipe_pkg::*;
#(
  parameter bit LAST = 1'b0
) (
  input  logic [127:0] st_i,
  input  logic [127:0] rk_i,
  output logic [127:0] st_o
);
  logic [127:0] sub_w;
  logic [127:0] rot_w;
  logic [127:0] mix_w;

  // byte substitution, one unit per byte
  for (genvar i = 0; i < 16; i++) begin : g_sub
    aes_sbox u_sbox (.din(st_i[127-8*i -: 8]), .dout(sub_w[127-8*i -: 8]));
  end

  // row r rotates left by r columns
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign rot_w[127-8*(r+4*c) -: 8] = sub_w[127-8*(r+4*((c+r)%4)) -: 8];
    end
  end

  if (LAST) begin : g_nomix
    assign mix_w = rot_w;
  end else begin : g_mix
    for (genvar c = 0; c < 4; c++) begin : g_mcol
      byte_t a0, a1, a2, a3;
      assign a0 = rot_w[127-32*c -: 8];
      assign a1 = rot_w[119-32*c -: 8];
      assign a2 = rot_w[111-32*c -: 8];
      assign a3 = rot_w[103-32*c -: 8];
      assign mix_w[127-32*c -: 8] = dbl(a0) ^ dbl(a1) ^ a1 ^ a2 ^ a3;
      assign mix_w[119-32*c -: 8] = a0 ^ dbl(a1) ^ dbl(a2) ^ a2 ^ a3;
      assign mix_w[111-32*c -: 8] = a0 ^ a1 ^ dbl(a2) ^ dbl(a3) ^ a3;
      assign mix_w[103-32*c -: 8] = dbl(a0) ^ a0 ^ a1 ^ a2 ^ dbl(a3);
    end
  end

  assign st_o = mix_w ^ rk_i;
endmodule

// File: rtl/aes_valid_track.sv
module aes_valid_track #(
  parameter int unsigned DEPTH = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic [DEPTH-1:0] vld
);
  localparam int unsigned CW = $clog2(DEPTH + 1) + 1;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[DEPTH-2:0], in_valid};
  end

  // independent occupancy count: entries minus exits
  logic [CW-1:0] occ_q;
  logic [CW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      age_q <= '0;
    end else begin
      occ_q <= occ_q + CW'(in_valid) - CW'(vld[DEPTH-1]);
      if (age_q < CW'(DEPTH)) age_q <= age_q + 1'b1;
    end
  end

  // R5: flagged stages always equal blocks admitted but not yet emitted
  p_occupancy_match_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) == int'(occ_q));

  // R6: nothing can leave before a block has crossed the whole depth
  p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (age_q < CW'(DEPTH)) |-> !vld[DEPTH-1]);
endmodule

// File: rtl/aes128_pipe.sv
module aes128_pipe #(
  parameter int unsigned NR = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [127:0]           in_block,
  input  logic [128*(NR+1)-1:0]  round_keys,
  output logic                   out_valid,
  output logic [127:0]           out_block
);
  localparam int unsigned NSTAGE = NR + 1;
  localparam int unsigned KEY_W  = 128 * NSTAGE;

  logic [NSTAGE-1:0]         vld;
  logic [NSTAGE-1:0][127:0]  st_q;
  logic [NR-1:0][127:0]      rnd_d;

  aes_valid_track #(.DEPTH(NSTAGE)) u_vtrack (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .vld      (vld)
  );

  // round i+1 reads stage i and the key slot i+1
  for (genvar i = 0; i < NR; i++) begin : g_rnd
    aes_round #(.LAST(i == NR - 1)) u_round (
      .st_i (st_q[i]),
      .rk_i (round_keys[KEY_W-1-128*(i+1) -: 128]),
      .st_o (rnd_d[i])
    );
  end

  // data registers load only when a real block arrives, bubbles hold
  always_ff @(posedge clk) begin
    if (in_valid) st_q[0] <= in_block ^ round_keys[KEY_W-1 -: 128];
    for (int i = 1; i < NSTAGE; i++) begin
      if (vld[i-1]) st_q[i] <= rnd_d[i-1];
    end
  end

  assign out_valid = vld[NSTAGE-1];
  assign out_block = st_q[NSTAGE-1];

  // R2: a flagged ciphertext is always fully defined
  p_data_known_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_block));

  // R6: the output flag is defined in every cycle after reset
  p_flag_known_r6: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(out_valid));
endmodule

// File: tb/aes128_pipe_test.sv
`timescale 1ns/1ps
module aes128_pipe_test;
  localparam int HMAX = 512;
  localparam int LAT  = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [127:0]  in_block = '0;
  logic [1407:0] round_keys = '0;
  logic          out_valid;
  logic [127:0]  out_block;

  aes128_pipe uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
    .round_keys(round_keys), .out_valid(out_valid), .out_block(out_block)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic         hist_v [HMAX];
  logic [127:0] hist_d [HMAX];
  logic         obs_v;
  logic [127:0] obs_d;
  logic [7:0]   sb [256];
  logic [127:0] rkey [11];
  logic [31:0]  lfsr = 32'hace1_2468;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    logic [7:0] ex [256];
    int lg [256];
    logic [7:0] x;
    logic [7:0] v;
    x = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = x;
      lg[x] = i;
      x = xt(x) ^ x;
    end
    for (int a = 0; a < 256; a++) begin
      v = (a == 0) ? 8'h00 : ex[(255 - lg[a]) % 255];
      sb[a] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
              {v[3:0], v[7:4]} ^ 8'h63;
    end
  endtask

  // R7: expand the cipher key, slot k at [1407-128k -: 128]
  task automatic load_key(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k < 11; k++) begin
      rkey[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
      round_keys[1407-128*k -: 128] = rkey[k];
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [4][4];
    logic [7:0] u [4][4];
    logic [127:0] v;
    v = pt ^ rkey[0];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) s[i%4][i/4] = sb[v[127-8*i -: 8]];
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) u[r][c] = s[r][(c+r)%4];
      if (rd < 10) begin
        for (int c = 0; c < 4; c++) begin
          s[0][c] = xt(u[0][c]) ^ xt(u[1][c]) ^ u[1][c] ^ u[2][c] ^ u[3][c];
          s[1][c] = u[0][c] ^ xt(u[1][c]) ^ xt(u[2][c]) ^ u[2][c] ^ u[3][c];
          s[2][c] = u[0][c] ^ u[1][c] ^ xt(u[2][c]) ^ xt(u[3][c]) ^ u[3][c];
          s[3][c] = xt(u[0][c]) ^ u[0][c] ^ u[1][c] ^ u[2][c] ^ xt(u[3][c]);
        end
      end else begin
        s = u;
      end
      for (int i = 0; i < 16; i++) v[127-8*i -: 8] = s[i%4][i/4];
      v = v ^ rkey[rd];
    end
    return v;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] next_rand();
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      r[127-32*i -: 32] = lfsr;
    end
    return r;
  endfunction

  // one cycle: judge the output against the block driven LAT negedges ago, then drive
  task automatic step(input logic r, input logic v, input logic [127:0] d,
                      input string tag);
    logic exp_v;
    int j;
    @(negedge clk);
    obs_v = out_valid;
    obs_d = out_block;
    j = (cyc - LAT + HMAX) % HMAX;
    exp_v = (cyc >= LAT) ? hist_v[j] : 1'b0;
    check(obs_v === exp_v, tag, {127'h0, obs_v}, {127'h0, exp_v});
    if (exp_v && obs_v) check(obs_d === ref_enc(hist_d[j]), "R2 data", obs_d, ref_enc(hist_d[j]));
    rst = r;
    in_valid = v;
    in_block = d;
    if (r) for (int k = 0; k < HMAX; k++) hist_v[k] = 1'b0;
    hist_v[cyc % HMAX] = v && !r;
    hist_d[cyc % HMAX] = d;
    cyc++;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: got %0d expected 0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < HMAX; k++) hist_v[k] = 1'b0;
    build_sbox();
    load_key(128'h000102030405060708090a0b0c0d0e0f);
    // R6: reset state, flag low throughout
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, "R6 reset");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, '0, "R6 idle");

    // R1/R3/R8: single known block, exact latency, one-cycle flag
    step(1'b0, 1'b1, 128'h00112233445566778899aabbccddeeff, "R3");
    for (int k = 1; k <= 13; k++) begin
      step(1'b0, 1'b0, '0, "R3 latency");
      check(obs_v === (k == LAT), "R8 single-cycle flag", {127'h0, obs_v}, {127'h0, 1'b1 & (k == LAT)});
      if (k == LAT) check(obs_d === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 known answer",
                          obs_d, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    end

    // R4: back-to-back stream
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, next_rand(), "R4 stream");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, '0, "R4 drain");

    // R5: irregular gaps must reappear ten edges later
    for (int i = 0; i < 70; i++)
      step(1'b0, ((i % 3) != 1) && ((i % 7) != 5), next_rand(), "R5 gaps");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, '0, "R5 drain");

    // R2: zero key, every byte value in every position
    load_key('0);
    for (int v = 0; v < 256; v++) step(1'b0, 1'b1, {16{8'(v)}}, "R2 sweep");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, '0, "R2 drain");

    // R7: fresh key, mixed stream
    load_key(next_rand());
    for (int i = 0; i < 30; i++) step(1'b0, (i % 4) != 3, next_rand(), "R7 key slots");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, '0, "R7 drain");

    // R9: reset with full pipeline and a block presented in the reset cycle
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, next_rand(), "R9 fill");
    step(1'b1, 1'b1, next_rand(), "R9 reset");
    for (int i = 0; i < 14; i++) step(1'b0, 1'b0, '0, "R9 flushed");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, next_rand(), "R9 resume");
    for (int i = 0; i < 13; i++) step(1'b0, 1'b0, '0, "R9 resume drain");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule